// File: doc/BRIEF.md
# NAND Command, Identifier and Reset Front End

This block models the command side of an 8-bit NAND flash I/O interface. It decodes single-cycle write strobes into command bytes or address bytes, depending on the two latch-select inputs. It recognises two commands. The identifier command (90h) is followed by a 00h address byte and selects a sticky identifier read mode. In that mode, successive read strobes return a fixed four-byte identifier. The reset command (FFh) pulls the active-low ready/busy output low for a programmable number of cycles and loads the status register with a preset value.

When a reset arrives while the array logic reports a random read, program or erase in progress, the block raises a one-cycle abort request. While the reset period runs, the block accepts no command byte and no address byte. A second reset in that window therefore cannot extend or restart the busy time. The device code, the fourth identifier byte and the reset duration in cycles are parameters.

Top module: `nand_cmd_front`

## Requirements
- R1: A write strobe captures a command byte only when `cle`=1 and `ale`=0, and an address byte only when `ale`=1 and `cle`=0. Strobes with both selects high or both low have no effect.
- R2: Command 90h followed by address 00h enters identifier mode. The next four read strobes return ADh, then DEV_CODE, then 00h, then ID_BYTE4. `dout` updates on the clock edge that samples the read strobe.
- R3: In identifier mode, every read strobe after the fourth returns ID_BYTE4 again.
- R4: Identifier mode is left on any other command byte. A 90h followed by a nonzero address byte does not enter it.
- R5: Each new 90h command restarts the identifier sequence at its first byte (ADh).
- R6: A command FFh written while ready drives `rb_n` low from the next edge for exactly RST_CYCLES cycles, after which it returns high.
- R7: Accepting FFh loads `status` with {`wprot_n`, 1, 1, 00000b}: E0h when `wprot_n` is high and 60h when it is low. After power-on reset, `status` is E0h.
- R8: While `rb_n` is low, all command and address bytes are ignored, including a further FFh. The busy period is not restarted.
- R9: An accepted reset leaves identifier mode, so later reads return 00h.
- R10: `op_abort` pulses high for one cycle, on the edge after an accepted FFh, only if `op_busy` was high at that write. Otherwise it stays low.
- R11: A read strobe outside identifier mode returns 00h on `dout`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous power-on reset |
| cle | input | 1 | Command latch select |
| ale | input | 1 | Address latch select |
| we_stb | input | 1 | One-cycle write strobe for `io_in` |
| re_stb | input | 1 | One-cycle read strobe |
| wprot_n | input | 1 | Write-protect pin, high means writes allowed |
| io_in | input | 8 | Command or address byte |
| op_busy | input | 1 | Array reports a read, program or erase in progress |
| dout | output | 8 | Read data byte |
| rb_n | output | 1 | Ready/busy, low while resetting |
| status | output | 8 | Status register |
| op_abort | output | 1 | One-cycle abort request to the array logic |

## Verification
Every result is one register stage behind its stimulus. The first three are due on the edge that samples the strobe:
- `dout` after a read strobe.
- `status` and `op_abort` after a reset write.
- The fall of `rb_n` after a reset write.

The rise of `rb_n` follows RST_CYCLES edges later. The bench drives each strobe at a falling edge and removes it at the next falling edge, then samples there, half a cycle after the edge that produced the result. The busy time is measured by a falling-edge counter of low `rb_n` cycles, so an ignored second reset shows up as a count that stays at RST_CYCLES.

// File: rtl/nand_fe_pkg.sv
package nand_fe_pkg;
  localparam logic [7:0] CMD_ID    = 8'h90;
  localparam logic [7:0] CMD_RST   = 8'hFF;
  localparam logic [7:0] MAKER_ID  = 8'hAD;
  localparam logic [7:0] STAT_INIT = 8'hE0;

  function automatic logic [7:0] id_byte(input logic [1:0] idx,
                                         input logic [7:0] dev,
                                         input logic [7:0] fourth);
    case (idx)
      2'd0:    id_byte = MAKER_ID;
      2'd1:    id_byte = dev;
      2'd2:    id_byte = 8'h00;
      default: id_byte = fourth;
    endcase
  endfunction

  function automatic logic [7:0] status_preset(input logic wp_ok);
    status_preset = {wp_ok, 2'b11, 5'b00000};
  endfunction
endpackage

// File: rtl/nand_latch_dec.sv
module nand_latch_dec (
  input  logic cle,
  input  logic ale,
  input  logic we_stb,
  output logic cmd_wr,
  output logic addr_wr
);
  always_comb begin
    cmd_wr  = we_stb & cle & ~ale;
    addr_wr = we_stb & ale & ~cle;
  end
endmodule

// File: rtl/nand_id_reader.sv
module nand_id_reader
  import nand_fe_pkg::*;
#(
  parameter logic [7:0] DEV_CODE = 8'hDC,
  parameter logic [7:0] ID_BYTE4 = 8'h95
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_ok,
  input  logic       addr_ok,
  input  logic       rd_ok,
  input  logic [7:0] byte_in,
  output logic       id_mode,
  output logic [1:0] id_idx,
  output logic [7:0] dout
);
  logic armed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed   <= 1'b0;
      id_mode <= 1'b0;
      id_idx  <= 2'd0;
    end else if (cmd_ok) begin
      armed   <= (byte_in == CMD_ID);
      id_mode <= 1'b0;
      if (byte_in == CMD_ID) id_idx <= 2'd0;
    end else if (addr_ok && armed) begin
      armed   <= 1'b0;
      id_mode <= (byte_in == 8'h00);
    end else if (rd_ok && id_mode && id_idx != 2'd3) begin
      id_idx <= id_idx + 2'd1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     dout <= 8'h00;
    else if (rd_ok) dout <= id_mode ? id_byte(id_idx, DEV_CODE, ID_BYTE4) : 8'h00;
  end
endmodule

// File: rtl/nand_reset_timer.sv
module nand_reset_timer #(
  parameter int RST_CYCLES = 20,
  localparam int CNT_W = $clog2(RST_CYCLES + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  output logic [CNT_W-1:0] busy_cnt,
  output logic             busy
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              busy_cnt <= '0;
    else if (start)          busy_cnt <= CNT_W'(RST_CYCLES);
    else if (busy_cnt != '0) busy_cnt <= busy_cnt - 1'b1;
  end

  assign busy = (busy_cnt != '0);
endmodule

// File: rtl/nand_cmd_front.sv
module nand_cmd_front
  import nand_fe_pkg::*;
#(
  parameter int         RST_CYCLES = 20,
  parameter logic [7:0] DEV_CODE   = 8'hDC,
  parameter logic [7:0] ID_BYTE4   = 8'h95,
  localparam int CNT_W = $clog2(RST_CYCLES + 1)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cle,
  input  logic       ale,
  input  logic       we_stb,
  input  logic       re_stb,
  input  logic       wprot_n,
  input  logic [7:0] io_in,
  input  logic       op_busy,
  output logic [7:0] dout,
  output logic       rb_n,
  output logic [7:0] status,
  output logic       op_abort
);
  logic             cmd_wr, addr_wr;
  logic             cmd_ok, addr_ok, rst_go;
  logic             busy;
  logic [CNT_W-1:0] busy_cnt;
  logic             id_mode;
  logic [1:0]       id_idx;

  nand_latch_dec u_dec (
    .cle(cle), .ale(ale), .we_stb(we_stb),
    .cmd_wr(cmd_wr), .addr_wr(addr_wr)
  );

  assign cmd_ok  = cmd_wr & ~busy;
  assign addr_ok = addr_wr & ~busy;
  assign rst_go  = cmd_ok & (io_in == CMD_RST);

  nand_id_reader #(.DEV_CODE(DEV_CODE), .ID_BYTE4(ID_BYTE4)) u_id (
    .clk(clk), .rst_n(rst_n), .cmd_ok(cmd_ok), .addr_ok(addr_ok),
    .rd_ok(re_stb), .byte_in(io_in), .id_mode(id_mode),
    .id_idx(id_idx), .dout(dout)
  );

  nand_reset_timer #(.RST_CYCLES(RST_CYCLES)) u_tmr (
    .clk(clk), .rst_n(rst_n), .start(rst_go),
    .busy_cnt(busy_cnt), .busy(busy)
  );

  assign rb_n = ~busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status   <= STAT_INIT;
      op_abort <= 1'b0;
    end else begin
      op_abort <= rst_go & op_busy;
      if (rst_go) status <= status_preset(wprot_n);
    end
  end
endmodule

// File: rtl/nand_cmd_front_chk.sv
module nand_cmd_front_chk #(
  parameter int CNT_W = 5,
  parameter logic [7:0] DEV_CODE = 8'hDC
) (
  input logic             clk,
  input logic             rst_n,
  input logic             rst_go,
  input logic             cmd_ok,
  input logic             cmd_wr,
  input logic             addr_wr,
  input logic             re_stb,
  input logic             wprot_n,
  input logic             op_busy,
  input logic             id_mode,
  input logic [1:0]       id_idx,
  input logic [CNT_W-1:0] busy_cnt,
  input logic [7:0]       dout,
  input logic             rb_n,
  input logic [7:0]       status,
  input logic             op_abort
);
  AST_LATCH_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(cmd_wr && addr_wr)); // R1
  AST_ID_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    re_stb && id_mode && id_idx == 2'd0 |=> dout == 8'hAD); // R2
  AST_ID_SECOND: assert property (@(posedge clk) disable iff (!rst_n)
    re_stb && id_mode && id_idx == 2'd1 |=> dout == DEV_CODE); // R2
  AST_IDX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    id_mode && id_idx == 2'd3 && !cmd_ok |=> id_idx == 2'd3); // R3
  AST_CMD_EXITS_ID: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ok |=> !id_mode); // R4
  AST_RB_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    rst_go |=> !rb_n); // R6
  AST_STATUS_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    rst_go |=> status == {$past(wprot_n), 7'b1100000}); // R7
  AST_BUSY_COUNTDOWN: assert property (@(posedge clk) disable iff (!rst_n)
    busy_cnt != '0 |=> (busy_cnt + 1'b1) == $past(busy_cnt)); // R8
  AST_ABORT_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    op_abort |-> $past(rst_go && op_busy)); // R10
  AST_ABORT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    op_abort |=> !op_abort); // R10
  AST_READ_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    re_stb && !id_mode |=> dout == 8'h00); // R11
endmodule

bind nand_cmd_front nand_cmd_front_chk #(.CNT_W(CNT_W), .DEV_CODE(DEV_CODE)) u_chk (
  .clk(clk), .rst_n(rst_n), .rst_go(rst_go), .cmd_ok(cmd_ok),
  .cmd_wr(cmd_wr), .addr_wr(addr_wr), .re_stb(re_stb), .wprot_n(wprot_n),
  .op_busy(op_busy), .id_mode(id_mode), .id_idx(id_idx),
  .busy_cnt(busy_cnt), .dout(dout), .rb_n(rb_n), .status(status),
  .op_abort(op_abort)
);

// File: tb/sim_nand_cmd_front.sv
module sim_nand_cmd_front;
  localparam int         NRST = 20;
  localparam logic [7:0] DEV  = 8'hDC;
  localparam logic [7:0] ID4  = 8'h95;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cle = 0, ale = 0, we_stb = 0, re_stb = 0, wprot_n = 1, op_busy = 0;
  logic [7:0] io_in = 8'h00;
  logic [7:0] dout, status;
  logic rb_n, op_abort;
  int errors = 0, checks = 0;
  int lowcnt = 0;
  bit meas = 0;

  always #10 clk = ~clk;

  nand_cmd_front #(.RST_CYCLES(NRST), .DEV_CODE(DEV), .ID_BYTE4(ID4)) u0 (
    .clk(clk), .rst_n(rst_n), .cle(cle), .ale(ale), .we_stb(we_stb),
    .re_stb(re_stb), .wprot_n(wprot_n), .io_in(io_in), .op_busy(op_busy),
    .dout(dout), .rb_n(rb_n), .status(status), .op_abort(op_abort)
  );

  always @(negedge clk) if (meas && !rb_n) lowcnt++;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // kind: 0 command, 1 address, 2 read, 3 command with both selects, 4 address with both selects
  task automatic strobe(input int kind, input logic [7:0] b);
    @(negedge clk);
    io_in = b;
    case (kind)
      0: begin cle = 1; ale = 0; we_stb = 1; end
      1: begin cle = 0; ale = 1; we_stb = 1; end
      2: re_stb = 1;
      default: begin cle = 1; ale = 1; we_stb = 1; end
    endcase
    @(negedge clk);
    cle = 0; ale = 0; we_stb = 0; re_stb = 0;
  endtask

  // {kind, req, data, expected}
  localparam logic [27:0] VEC [24] = '{
    {4'd0, 8'd2,  8'h90, 8'h00}, {4'd1, 8'd2,  8'h00, 8'h00},
    {4'd2, 8'd2,  8'h00, 8'hAD}, {4'd2, 8'd2,  8'h00, DEV},   // R2
    {4'd2, 8'd2,  8'h00, 8'h00}, {4'd2, 8'd2,  8'h00, ID4},   // R2
    {4'd2, 8'd3,  8'h00, ID4},   {4'd2, 8'd3,  8'h00, ID4},   // R3
    {4'd3, 8'd1,  8'h70, 8'h00}, {4'd2, 8'd1,  8'h00, ID4},   // R1
    {4'd0, 8'd5,  8'h90, 8'h00}, {4'd1, 8'd5,  8'h00, 8'h00},
    {4'd2, 8'd5,  8'h00, 8'hAD}, {4'd2, 8'd5,  8'h00, DEV},   // R5
    {4'd0, 8'd4,  8'h70, 8'h00}, {4'd2, 8'd4,  8'h00, 8'h00}, // R4
    {4'd0, 8'd4,  8'h90, 8'h00}, {4'd1, 8'd4,  8'h05, 8'h00},
    {4'd2, 8'd4,  8'h00, 8'h00}, {4'd0, 8'd1,  8'h90, 8'h00}, // R4
    {4'd4, 8'd1,  8'h00, 8'h00}, {4'd2, 8'd1,  8'h00, 8'h00}, // R1
    {4'd1, 8'd1,  8'h00, 8'h00}, {4'd2, 8'd1,  8'h00, 8'hAD}  // R1
  };

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : main
    int n;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R6 reset rb_n", rb_n, 1);
    chk("R7 reset status", status, 8'hE0);
    chk("R10 reset abort", op_abort, 0);
    strobe(2, 8'h00);
    chk("R11 idle read", dout, 8'h00);

    foreach (VEC[i]) begin
      strobe(int'(VEC[i][27:24]), VEC[i][15:8]);
      if (VEC[i][27:24] == 4'd2)
        chk($sformatf("R%0d vec %0d", VEC[i][23:16], i), dout, VEC[i][7:0]);
    end

    // still in identifier mode here; reset with protect active and array busy
    wprot_n = 0; op_busy = 1;
    meas = 1; lowcnt = 0;
    strobe(0, 8'hFF);
    op_busy = 0;
    chk("R10 abort pulse", op_abort, 1);
    chk("R6 rb_n low", rb_n, 0);
    chk("R7 status protected", status, 8'h60);
    @(negedge clk);
    chk("R10 abort one cycle", op_abort, 0);
    wprot_n = 1;
    strobe(0, 8'hFF);                 // R8 ignored while busy
    chk("R8 status unchanged", status, 8'h60);
    strobe(0, 8'h90);
    strobe(1, 8'h00);
    n = 0;
    while (!rb_n && n < 100) begin @(negedge clk); n++; end
    repeat (3) @(negedge clk);
    meas = 0;
    chk("R6 R8 busy length", lowcnt, NRST);
    strobe(2, 8'h00);
    chk("R9 R8 no id after reset", dout, 8'h00);

    // reset while ready, write allowed, array idle
    strobe(0, 8'hFF);
    chk("R7 status open", status, 8'hE0);
    chk("R10 no abort when idle", op_abort, 0);
    while (!rb_n) @(negedge clk);
    strobe(0, 8'h90);
    strobe(1, 8'h00);
    strobe(2, 8'h00);
    chk("R9 id works after reset", dout, 8'hAD);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule